// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches the running calendar time, given as six BCD fields by the timekeeping logic, and compares it with six alarm bytes that software programs over a simple register bus. The six fields are seconds, minutes, hours, day of week, day of month and month. Each alarm byte has its own compare enable in its top bit, so software can build an alarm such as "every day at 07:30:00" or "each Monday" by enabling only the fields it cares about. The year is not part of the compare.

When every enabled field equals the current time, the unit latches an alarm flag. The flag is set once for each new match and stays set until software writes a zero to it. An interrupt line is driven high while the flag is set and the alarm interrupt enable is on. Software reaches the alarm bytes, the flag and the enable through one write port and one combinational read port.

Top module: `alm_cmp_top`

## Requirements
- R1: After synchronous reset, all six alarm bytes read 0x00, and the alarm flag, the interrupt enable and the interrupt output are all 0.
- R2: The alarm bytes are at bus addresses 8 to 13, in this order: seconds, minutes, hours, day of week, day of month, month (month is 1 to 12). A write stores all 8 bits, and a read returns them. The control byte is at address 14, with the alarm flag in bit 0, the interrupt enable in bit 3, and the other bits reading 0. Every other address reads 0x00.
- R3: Bit 7 of an alarm byte enables that field. Bits 6:0 are compared with the 7-bit BCD time field of the same kind. A field whose bit 7 is 0 takes no part in the compare, whatever its value bits hold.
- R4: A match needs every enabled field to equal its time field. A single enabled field that differs blocks the match.
- R5: With no field enabled, the alarm flag is never set.
- R6: The flag is set on the first clock edge at which the match condition holds after a cycle in which it did not hold. A match that lasts many cycles sets the flag only once. After software clears the flag, it is not set again until the match has ended and begun again.
- R7: Once set, the flag stays set until a control-byte write has bit 0 equal to 0. A control write with bit 0 equal to 1 never sets the flag.
- R8: When a new match and a clearing control write fall on the same clock edge, the flag ends up set.
- R9: The interrupt output is high exactly when both the flag and the interrupt enable are 1. The enable takes bit 3 of each control-byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 7 | Current hours, BCD |
| tm_wday | input | 7 | Current day of week, BCD |
| tm_mday | input | 7 | Current day of month, BCD |
| tm_mon | input | 7 | Current month, BCD 1 to 12 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for write and read |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| alarm_flag | output | 1 | Latched alarm flag |
| alarm_ie | output | 1 | Alarm interrupt enable |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench programs disabled fields that hold values which differ from the time. A design that ignored the enable bit would then never fire. It also drives a time in which only one enabled field differs, to catch a design that fires on a partial match, and it leaves every field disabled, to catch a design whose empty compare counts as a hit. It holds a match for many cycles across a software clear, which exposes a design that sets the flag on the level instead of the edge. It places a clearing write on the exact edge where a new match begins, where a design that gives the clear priority would lose the alarm. Random time patterns, biased toward the programmed alarm, are checked cycle by cycle against a bench model.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;

    localparam int N_FIELDS = 6;
    localparam int BCD_W    = 7;
    localparam int BYTE_W   = 8;

    // one alarm byte: compare enable in the top bit, BCD value below it
    typedef struct packed {
        logic             en;
        logic [BCD_W-1:0] val;
    } alm_field_t;

    // field order is the bus order of the alarm bytes
    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5
    } fld_idx_e;

    typedef struct packed {
        logic flag;
        logic ie;
    } alm_ctrl_t;

    function automatic logic fld_hit(alm_field_t a, logic [BCD_W-1:0] cur);
        return (!a.en) || (a.val == cur);
    endfunction

endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
    import alm_cmp_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int ALARM_BASE = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             wdata,
    output alm_field_t [N_FIELDS-1:0]     fields
);

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
        localparam logic [ADDR_W-1:0] FLD_ADDR = ADDR_W'(ALARM_BASE + i);
        alm_field_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (addr == FLD_ADDR)) begin
                q <= alm_field_t'(wdata);
            end
        end
        assign fields[i] = q;
    end

endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_cmp_pkg::*;
(
    input  alm_field_t [N_FIELDS-1:0]              fields,
    input  logic       [N_FIELDS-1:0][BCD_W-1:0]   cur,
    output logic                                   match,
    output logic                                   any_en
);

    logic [N_FIELDS-1:0] hit;
    logic [N_FIELDS-1:0] en_vec;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
        assign hit[i]    = fld_hit(fields[i], cur[i]);
        assign en_vec[i] = fields[i].en;
    end

    always_comb begin
        any_en = |en_vec;
        match  = any_en && (&hit);
    end

endmodule

// File: rtl/alm_flag_ctrl.sv
module alm_flag_ctrl
    import alm_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      match,
    input  logic      ctrl_wr,
    input  logic      flag_wbit,
    input  logic      ie_wbit,
    output alm_ctrl_t ctrl,
    output logic      irq
);

    logic match_q;
    logic set_pulse;
    logic clr_req;

    always_comb begin
        set_pulse = match && !match_q;
        clr_req   = ctrl_wr && !flag_wbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= 1'b0;
            ctrl.flag <= 1'b0;
            ctrl.ie   <= 1'b0;
        end else begin
            match_q <= match;
            if (set_pulse) begin
                ctrl.flag <= 1'b1;
            end else if (clr_req) begin
                ctrl.flag <= 1'b0;
            end
            if (ctrl_wr) begin
                ctrl.ie <= ie_wbit;
            end
        end
    end

    assign irq = ctrl.flag && ctrl.ie;

    // R8: a new match wins over a clear on the same edge
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> ctrl.flag);

    // R6: one set per match episode
    a_r6_single_set: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> !set_pulse);

    // R7: flag holds without a clear
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flag && !clr_req) |=> ctrl.flag);

    // R7: a control write with bit 0 high and no match start leaves a clear flag clear
    a_r7_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.flag && !set_pulse) |=> !ctrl.flag);

endmodule

// File: rtl/alm_cmp_top.sv
module alm_cmp_top
    import alm_cmp_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int ALARM_BASE = 8,
    parameter int CTRL_ADDR  = 14,
    parameter int FLAG_BIT   = 0,
    parameter int IE_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        tm_sec,
    input  logic [6:0]        tm_min,
    input  logic [6:0]        tm_hour,
    input  logic [6:0]        tm_wday,
    input  logic [6:0]        tm_mday,
    input  logic [6:0]        tm_mon,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              alarm_flag,
    output logic              alarm_ie,
    output logic              alarm_irq
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ALARM_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(ALARM_BASE + N_FIELDS - 1);

    alm_field_t [N_FIELDS-1:0]            fields;
    logic       [N_FIELDS-1:0][BCD_W-1:0] cur;
    logic                                 match;
    logic                                 any_en;
    logic                                 ctrl_wr;
    alm_ctrl_t                            ctrl;
    logic       [ADDR_W-1:0]              fld_off;

    always_comb begin
        cur[FLD_SEC]  = tm_sec;
        cur[FLD_MIN]  = tm_min;
        cur[FLD_HOUR] = tm_hour;
        cur[FLD_WDAY] = tm_wday;
        cur[FLD_MDAY] = tm_mday;
        cur[FLD_MON]  = tm_mon;
    end

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);

    alm_regfile #(
        .ADDR_W     (ADDR_W),
        .ALARM_BASE (ALARM_BASE)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .fields (fields)
    );

    alm_match u_match (
        .fields (fields),
        .cur    (cur),
        .match  (match),
        .any_en (any_en)
    );

    alm_flag_ctrl u_flag (
        .clk       (clk),
        .rst       (rst),
        .match     (match),
        .ctrl_wr   (ctrl_wr),
        .flag_wbit (bus_wdata[FLAG_BIT]),
        .ie_wbit   (bus_wdata[IE_BIT]),
        .ctrl      (ctrl),
        .irq       (alarm_irq)
    );

    assign alarm_flag = ctrl.flag;
    assign alarm_ie   = ctrl.ie;

    // combinational read mux
    always_comb begin
        fld_off   = bus_addr - BASE_A;
        bus_rdata = '0;
        if (bus_addr == CTRL_A) begin
            bus_rdata[FLAG_BIT] = ctrl.flag;
            bus_rdata[IE_BIT]   = ctrl.ie;
        end else if (bus_addr >= BASE_A && bus_addr <= LAST_A) begin
            bus_rdata = fields[fld_off[2:0]];
        end
    end

    // R5: with no field enabled the compare never hits
    a_r5_empty_no_match: assert property (@(posedge clk) disable iff (rst)
        !any_en |-> !match);

    // R9: the interrupt needs both the flag and the enable
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (alarm_flag && alarm_ie));

    // R1: state is clear on the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!alarm_flag && !alarm_ie));

endmodule

// File: tb/alm_cmp_top_tb.sv
module alm_cmp_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] tm_sec, tm_min, tm_hour, tm_wday, tm_mday, tm_mon;
    logic       bus_wr;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       alarm_flag, alarm_ie, alarm_irq;

    int checks   = 0;
    int failures = 0;

    // bench model
    logic [7:0] m_alm [6];
    logic       m_flag, m_ie, m_match_q;

    always #2.5 clk = ~clk;

    alm_cmp_top u_dut (
        .clk(clk), .rst(rst),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_wday(tm_wday), .tm_mday(tm_mday), .tm_mon(tm_mon),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .alarm_flag(alarm_flag), .alarm_ie(alarm_ie), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic model_match();
        logic [6:0] t [6];
        logic any = 1'b0;
        logic all = 1'b1;
        t[0] = tm_sec; t[1] = tm_min; t[2] = tm_hour;
        t[3] = tm_wday; t[4] = tm_mday; t[5] = tm_mon;
        for (int i = 0; i < 6; i++) begin
            if (m_alm[i][7]) begin
                any = 1'b1;
                if (m_alm[i][6:0] != t[i]) all = 1'b0;
            end
        end
        return any && all;
    endfunction

    function automatic logic [6:0] rand_bcd(input int maxv);
        int v = int'($urandom % (maxv + 1));
        return 7'(((v / 10) << 4) | (v % 10));
    endfunction

    // one clock: inputs already driven; update model, step, check outputs
    task automatic step(input string req);
        logic mt;
        logic set_p;
        mt = model_match();
        set_p = mt && !m_match_q;
        m_match_q = mt;
        if (set_p) m_flag = 1'b1;
        else if (bus_wr && bus_addr == 4'd14 && !bus_wdata[0]) m_flag = 1'b0;
        if (bus_wr && bus_addr == 4'd14) m_ie = bus_wdata[3];
        if (bus_wr && bus_addr >= 4'd8 && bus_addr <= 4'd13) m_alm[bus_addr - 4'd8] = bus_wdata;
        @(posedge clk);
        #1;
        chk({req, " flag"}, {7'd0, alarm_flag}, {7'd0, m_flag});
        chk({req, " irq"},  {7'd0, alarm_irq},  {7'd0, m_flag && m_ie});
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(req);
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic set_time(input logic [6:0] s, mi, h, w, d, mo);
        tm_sec = s; tm_min = mi; tm_hour = h; tm_wday = w; tm_mday = d; tm_mon = mo;
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'h5EED_A1A3));
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        set_time(7'h00, 7'h00, 7'h00, 7'h0, 7'h01, 7'h01);
        for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
        m_flag = 0; m_ie = 0; m_match_q = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 8; a <= 13; a++) rd(4'(a), 8'h00, "R1 alarm byte reset");
        rd(4'd14, 8'h00, "R1 ctrl reset");
        chk("R1 irq reset", {7'd0, alarm_irq}, 8'h00);

        // R5 all disabled, value bits nonzero and time equal to them
        wr(4'd8, 8'h30, "R5 sec value no enable");
        set_time(7'h30, 7'h00, 7'h00, 7'h0, 7'h01, 7'h01);
        repeat (3) step("R5 no enabled field");

        // R2 register readback and map
        wr(4'd9,  8'hA5, "R2 wr min");
        wr(4'd10, 8'h87, "R2 wr hour");
        wr(4'd11, 8'h03, "R2 wr wday");
        wr(4'd12, 8'h9F, "R2 wr mday");
        wr(4'd13, 8'h92, "R2 wr mon");
        rd(4'd8,  8'h30, "R2 rd sec");
        rd(4'd9,  8'hA5, "R2 rd min");
        rd(4'd10, 8'h87, "R2 rd hour");
        rd(4'd11, 8'h03, "R2 rd wday");
        rd(4'd12, 8'h9F, "R2 rd mday");
        rd(4'd13, 8'h92, "R2 rd mon");
        rd(4'd5,  8'h00, "R2 unmapped low");
        rd(4'd15, 8'h00, "R2 unmapped high");
        wr(4'd15, 8'hFF, "R2 wr unmapped");
        rd(4'd13, 8'h92, "R2 unmapped write no effect");

        // R3/R4: program 07:30:00 enabled, wday disabled but mismatching
        wr(4'd8,  8'h80, "R3 sec en");
        wr(4'd9,  8'hB0, "R3 min en");
        wr(4'd10, 8'h87, "R3 hour en");
        wr(4'd11, 8'h05, "R3 wday disabled");
        wr(4'd12, 8'h00, "R3 mday off");
        wr(4'd13, 8'h00, "R3 mon off");
        wr(4'd14, 8'h08, "R9 ie on");
        rd(4'd14, 8'h08, "R2 ctrl ie bit");
        // R4 one enabled field off
        set_time(7'h00, 7'h31, 7'h07, 7'h2, 7'h11, 7'h04);
        repeat (2) step("R4 min mismatch");
        set_time(7'h00, 7'h30, 7'h08, 7'h2, 7'h11, 7'h04);
        repeat (2) step("R4 hour mismatch");
        // R3 match with disabled wday differing
        set_time(7'h00, 7'h30, 7'h07, 7'h2, 7'h11, 7'h04);
        step("R3 masked field match");
        chk("R3 flag set", {7'd0, alarm_flag}, 8'h01);
        chk("R9 irq high", {7'd0, alarm_irq}, 8'h01);
        rd(4'd14, 8'h09, "R2 ctrl flag bit");
        // R6 level holds: clear, no re-set
        repeat (3) step("R6 hold");
        wr(4'd14, 8'h08, "R6 clear during match");
        repeat (4) step("R6 no reset while held");
        chk("R6 flag stays clear", {7'd0, alarm_flag}, 8'h00);
        // R7 writing 1 does not set
        wr(4'd14, 8'h09, "R7 write one");
        chk("R7 write one no set", {7'd0, alarm_flag}, 8'h00);
        // new episode
        set_time(7'h01, 7'h30, 7'h07, 7'h2, 7'h11, 7'h04);
        step("R6 end match");
        set_time(7'h00, 7'h30, 7'h07, 7'h2, 7'h11, 7'h04);
        step("R6 new episode");
        chk("R6 reset on new episode", {7'd0, alarm_flag}, 8'h01);
        // R9 ie off keeps flag, drops irq
        wr(4'd14, 8'h01, "R9 ie off");
        chk("R9 irq low ie off", {7'd0, alarm_irq}, 8'h00);
        chk("R7 flag held", {7'd0, alarm_flag}, 8'h01);
        wr(4'd14, 8'h00, "R7 clear");
        chk("R7 cleared", {7'd0, alarm_flag}, 8'h00);

        // R8: clear on the same edge as a new match
        set_time(7'h02, 7'h30, 7'h07, 7'h2, 7'h11, 7'h04);
        step("R8 prep");
        wr(4'd14, 8'h08, "R8 ie on");
        set_time(7'h00, 7'h30, 7'h07, 7'h2, 7'h11, 7'h04);
        wr(4'd14, 8'h08, "R8 clear with new match");
        chk("R8 set wins", {7'd0, alarm_flag}, 8'h01);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] t [6];
            logic [6:0] mx [6];
            mx[0] = 7'h59; mx[1] = 7'h59; mx[2] = 7'h23;
            mx[3] = 7'h06; mx[4] = 7'h31; mx[5] = 7'h12;
            for (int i = 0; i < 6; i++) begin
                if ($urandom % 4 != 0) t[i] = m_alm[i][6:0];
                else t[i] = (i == 3) ? rand_bcd(6) : (i == 2) ? rand_bcd(23) :
                            (i == 4) ? rand_bcd(31) : (i == 5) ? rand_bcd(12) : rand_bcd(59);
            end
            set_time(t[0], t[1], t[2], t[3], t[4], t[5]);
            if ($urandom % 16 == 0) begin
                int f = int'($urandom % 6);
                logic [6:0] v;
                v = (f == 3) ? rand_bcd(6) : (f == 2) ? rand_bcd(23) : (f == 4) ? rand_bcd(31) :
                    (f == 5) ? rand_bcd(12) : rand_bcd(59);
                bus_wr = 1'b1; bus_addr = 4'(8 + f);
                bus_wdata = {($urandom % 3 != 0) ? 1'b1 : 1'b0, v};
            end else if ($urandom % 10 == 0) begin
                bus_wr = 1'b1; bus_addr = 4'd14;
                bus_wdata = {4'd0, 1'($urandom), 2'd0, 1'($urandom)};
            end
            step("R4 R6 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule